// File: doc/BRIEF.md
# Set-Associative Translation Cache with Random Refill

This block keeps recently used virtual-to-physical page number mappings in an array of sets, each set holding eight ways. A lookup takes a virtual address and drops the page offset. The next field up picks the set, and every bit above that field is the tag. The lookup answers within the same cycle: a hit flag, the cached physical page number, and a hint that names a way of that set still holding no entry.

After a miss, an external page walker produces the translation. The walker hands the virtual address, the new physical page number and the hint from the earlier lookup to the refill port. The entry goes into the hinted way when the hint is valid. When no way was free, a way picked by a free-running pseudo-random generator is overwritten. A refill that carries a zero physical page number is dropped. A synchronous flush input invalidates every entry at once, and so does reset.

Top module: `tlb_set_assoc`

## Requirements
- R1: A lookup hits when a way of the selected set has its valid bit set and a stored tag equal to the address tag. The hit flag is then 1 and the physical page number output carries that way's stored number, in the same cycle.
- R2: A lookup that finds no valid way with a matching tag drives the hit flag to 0 and the physical page number output to zero.
- R3: The set index is virtual address bits [OFF_W+IDX_W-1:OFF_W], and the tag is bits [VA_W-1:OFF_W+IDX_W]. The page offset bits [OFF_W-1:0] take no part in a lookup. With the defaults these are bits [15:12], [47:16] and [11:0]. An entry stored in one set never hits for a lookup that selects another set.
- R4: Each lookup reports the free-way hint with the free flag set to 1 and the way number equal to the highest-numbered invalid way of the selected set. When all eight ways are valid, the free flag is 0.
- R5: A refill with the hint-valid input at 1 writes the entry into the hinted way and sets that way's valid bit. The entry stores the physical page number and the tag of the refill address.
- R6: A refill with the hint-valid input at 0 overwrites exactly one way of the set. The way is picked from the low bits of a 16-bit maximal-length LFSR that is never all-zero. The new entry hits afterwards, and the other seven entries stay intact.
- R7: A refill whose physical page number is zero changes no entry.
- R8: A refill takes effect at the rising clock edge. A lookup in the same cycle still sees the previous contents.
- R9: Reset and a synchronous flush both clear every valid bit. A flush wins over a refill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| lk_vaddr_i | input | VA_W (48) | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PPN_W (40) | Physical page number on hit, zero on miss |
| lk_free_vld_o | output | 1 | Selected set has an invalid way |
| lk_free_way_o | output | WAY_W (3) | Highest-numbered invalid way |
| rf_req_i | input | 1 | Refill request |
| rf_vaddr_i | input | VA_W (48) | Refill virtual address |
| rf_ppn_i | input | PPN_W (40) | Refill physical page number; zero means drop |
| rf_hint_vld_i | input | 1 | Use the hinted way |
| rf_hint_way_i | input | WAY_W (3) | Hinted way from the earlier lookup |

## Verification
Assertions check several properties on every cycle:
- a miss always yields a zero page number;
- the free hint always names a way that is really invalid;
- the generator state never becomes zero;
- a flush empties the whole array;
- without a write or flush, the valid bits never move;
- each write leaves its target way valid.

Only the bench scenarios can show the rest:
- which way is picked, including the highest-free rule and the effect of a non-top hint;
- that a replacement displaces exactly one old entry;
- that a zero translation changes nothing;
- that same-cycle lookups see old data;
- that sets are kept apart.

// File: rtl/tlb_pkg.sv
// Shared constants for the translation cache.
// Assumes: the victim generator is 16 bits wide, with taps for x^16+x^14+x^13+x^11.
package tlb_pkg;
    localparam int unsigned LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/tlb_lfsr.sv
// Free-running Fibonacci LFSR that supplies pseudo-random victim ways.
// Assumes: SEED is nonzero, so the state can never lock up at zero.
module tlb_lfsr
    import tlb_pkg::*;
#(
    parameter int unsigned    W    = LFSR_W,
    parameter logic [W-1:0]   TAPS = LFSR_TAPS,
    parameter logic [W-1:0]   SEED = LFSR_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);
    logic [W-1:0] q;

    // Advance one step every cycle, and reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], ^(q & TAPS)};
    end

    assign state_o = q;

    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/tlb_way_array.sv
// Storage for valid bits, tags and page numbers of all sets and ways.
// The read of one set is combinational. One way is written per clock.
// Assumes: only valid bits are reset. Tag and page data are qualified by them.
module tlb_way_array #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 32,
    parameter int unsigned PPN_W = 40,
    localparam int unsigned SETS  = 1 << IDX_W,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush_i,
    input  logic [IDX_W-1:0]               rd_idx_i,
    output logic [WAYS-1:0]                rd_vld_o,
    output logic [WAYS-1:0][TAG_W-1:0]     rd_tag_o,
    output logic [WAYS-1:0][PPN_W-1:0]     rd_ppn_o,
    input  logic                           wr_en_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [WAY_W-1:0]               wr_way_i,
    input  logic [TAG_W-1:0]               wr_tag_i,
    input  logic [PPN_W-1:0]               wr_ppn_i
);
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [SETS*WAYS-1:0] vld_flat;

    // Valid bits: cleared by reset or flush, and set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i][wr_way_i] <= 1'b1;
        end
    end

    // Tag and page number payload: written alongside the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
            ppn_q[wr_idx_i][wr_way_i] <= wr_ppn_i;
        end
    end

    // Read port: present every way of the addressed set.
    always_comb begin
        rd_vld_o = vld_q[rd_idx_i];
        for (int w = 0; w < WAYS; w++) begin
            rd_tag_o[w] = tag_q[rd_idx_i][w];
            rd_ppn_o[w] = ppn_q[rd_idx_i][w];
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_flat
        assign vld_flat[s*WAYS +: WAYS] = vld_q[s];
    end

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_flat == '0));
    a_r7_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !flush_i) |=> $stable(vld_flat));
    a_r5_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> vld_q[$past(wr_idx_i)][$past(wr_way_i)]);
endmodule

// File: rtl/tlb_match.sv
// Tag compare across the ways of one set. Produces the hit flag, the page
// number and the highest-numbered invalid way.
// Assumes: at most one valid way per set holds a given tag.
module tlb_match #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 32,
    parameter int unsigned PPN_W = 40,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]            tag_i,
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_arr_i,
    input  logic [WAYS-1:0][PPN_W-1:0]  ppn_arr_i,
    output logic                        hit_o,
    output logic [PPN_W-1:0]            ppn_o,
    output logic                        free_vld_o,
    output logic [WAY_W-1:0]            free_way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_i[w] && (tag_arr_i[w] == tag_i);
    end

    // Hit mux: OR in the page number of the matching way, zero when none matches.
    always_comb begin
        ppn_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) ppn_o = ppn_o | ppn_arr_i[w];
    end
    assign hit_o = |match;

    // Free scan: the last invalid way seen in ascending order wins.
    always_comb begin
        free_vld_o = 1'b0;
        free_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld_i[w]) begin
                free_vld_o = 1'b1;
                free_way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tlb_set_assoc.sv
// Set-associative translation cache top. Splits the addresses, runs the
// lookup, and steers refills to the hinted way or to a random victim.
// Assumes: WAYS is a power of two and at most 2**16. The page walker sits outside.
module tlb_set_assoc
    import tlb_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 32,
    parameter int unsigned PPN_W = 40,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned WAYS  = 8,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned VA_W  = TAG_W + IDX_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VA_W-1:0]  lk_vaddr_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o,
    output logic             lk_free_vld_o,
    output logic [WAY_W-1:0] lk_free_way_o,
    input  logic             rf_req_i,
    input  logic [VA_W-1:0]  rf_vaddr_i,
    input  logic [PPN_W-1:0] rf_ppn_i,
    input  logic             rf_hint_vld_i,
    input  logic [WAY_W-1:0] rf_hint_way_i
);
    logic [IDX_W-1:0]              lk_idx, rf_idx;
    logic [TAG_W-1:0]              lk_tag, rf_tag;
    logic [WAYS-1:0]               rd_vld;
    logic [WAYS-1:0][TAG_W-1:0]    rd_tag;
    logic [WAYS-1:0][PPN_W-1:0]    rd_ppn;
    logic [LFSR_W-1:0]             rnd;
    logic                          wr_en;
    logic [WAY_W-1:0]              wr_way;

    // Field split: the offset is dropped, then come the index and the tag.
    assign lk_idx = lk_vaddr_i[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr_i[OFF_W+IDX_W +: TAG_W];
    assign rf_idx = rf_vaddr_i[OFF_W +: IDX_W];
    assign rf_tag = rf_vaddr_i[OFF_W+IDX_W +: TAG_W];

    // Refill steering: drop zero translations, a flush wins, and a valid hint beats the random pick.
    always_comb begin
        wr_en  = rf_req_i && (rf_ppn_i != '0) && !flush_i;
        wr_way = rf_hint_vld_i ? rf_hint_way_i : rnd[WAY_W-1:0];
    end

    tlb_lfsr i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (rnd)
    );

    tlb_way_array #(
        .IDX_W (IDX_W), .WAYS (WAYS), .TAG_W (TAG_W), .PPN_W (PPN_W)
    ) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .rd_idx_i (lk_idx),
        .rd_vld_o (rd_vld),
        .rd_tag_o (rd_tag),
        .rd_ppn_o (rd_ppn),
        .wr_en_i  (wr_en),
        .wr_idx_i (rf_idx),
        .wr_way_i (wr_way),
        .wr_tag_i (rf_tag),
        .wr_ppn_i (rf_ppn_i)
    );

    tlb_match #(
        .WAYS (WAYS), .TAG_W (TAG_W), .PPN_W (PPN_W)
    ) i_match (
        .tag_i      (lk_tag),
        .vld_i      (rd_vld),
        .tag_arr_i  (rd_tag),
        .ppn_arr_i  (rd_ppn),
        .hit_o      (lk_hit_o),
        .ppn_o      (lk_ppn_o),
        .free_vld_o (lk_free_vld_o),
        .free_way_o (lk_free_way_o)
    );

    a_r2_miss_ppn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit_o |-> (lk_ppn_o == '0));
    a_r4_free_way_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_free_vld_o |-> !rd_vld[lk_free_way_o]);
    a_r4_full_set_no_free: assert property (@(posedge clk) disable iff (!rst_n)
        (&rd_vld) |-> !lk_free_vld_o);
endmodule

// File: tb/test_tlb_set_assoc.sv
module test_tlb_set_assoc;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [47:0] lk_va = '0;
    logic        hit;
    logic [39:0] ppn;
    logic        fvld;
    logic [2:0]  fway;
    logic        rf_req = 1'b0;
    logic [47:0] rf_va = '0;
    logic [39:0] rf_ppn = '0;
    logic        hv = 1'b0;
    logic [2:0]  hw = '0;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_set_assoc i_tlb_set_assoc (
        .clk (clk), .rst_n (rst_n), .flush_i (flush),
        .lk_vaddr_i (lk_va), .lk_hit_o (hit), .lk_ppn_o (ppn),
        .lk_free_vld_o (fvld), .lk_free_way_o (fway),
        .rf_req_i (rf_req), .rf_vaddr_i (rf_va), .rf_ppn_i (rf_ppn),
        .rf_hint_vld_i (hv), .rf_hint_way_i (hw)
    );

    typedef struct packed {
        logic        op;   // 0 lookup and check, 1 refill
        logic [3:0]  set;
        logic [7:0]  tag;
        logic [15:0] pn;
        logic        hv;
        logic [2:0]  hw;
        logic        eh;
        logic [15:0] ep;
        logic        efv;
        logic [2:0]  efw;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b0, 4'd3, 8'h11, 16'h0000, 1'b0, 3'd0, 1'b0, 16'h0000, 1'b1, 3'd7}, // R2 R4 empty
        '{1'b1, 4'd3, 8'h11, 16'h00A1, 1'b1, 3'd7, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b0, 4'd3, 8'h11, 16'h0000, 1'b0, 3'd0, 1'b1, 16'h00A1, 1'b1, 3'd6}, // R1 R5
        '{1'b0, 4'd5, 8'h11, 16'h0000, 1'b0, 3'd0, 1'b0, 16'h0000, 1'b1, 3'd7}, // R3
        '{1'b1, 4'd3, 8'h22, 16'h0000, 1'b1, 3'd6, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b0, 4'd3, 8'h22, 16'h0000, 1'b0, 3'd0, 1'b0, 16'h0000, 1'b1, 3'd6}, // R7
        '{1'b1, 4'd3, 8'h22, 16'h00B2, 1'b1, 3'd2, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b0, 4'd3, 8'h22, 16'h0000, 1'b0, 3'd0, 1'b1, 16'h00B2, 1'b1, 3'd6}, // R5 way 2
        '{1'b0, 4'd3, 8'h33, 16'h0000, 1'b0, 3'd0, 1'b0, 16'h0000, 1'b1, 3'd6}  // R2
    };

    function automatic logic [47:0] mkva(input logic [3:0] s, input logic [7:0] t);
        return {24'h5A_0000, t, s, 12'hABC};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic refill(input logic [3:0] s, input logic [7:0] t, input logic [39:0] p,
                          input logic v, input logic [2:0] w);
        @(negedge clk);
        rf_req = 1'b1; rf_va = mkva(s, t); rf_ppn = p; hv = v; hw = w;
        @(negedge clk);
        rf_req = 1'b0; hv = 1'b0;
    endtask

    task automatic look(input logic [3:0] s, input logic [7:0] t);
        lk_va = mkva(s, t);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int olds;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look(4'd9, 8'h01);
        chk("R9 reset hit", 64'(hit), 64'd0);
        chk("R9 reset free", 64'({fvld, fway}), 64'({1'b1, 3'd7}));

        for (int i = 0; i < 9; i++) begin
            if (TBL[i].op) begin
                refill(TBL[i].set, TBL[i].tag, 40'(TBL[i].pn), TBL[i].hv, TBL[i].hw);
            end else begin
                @(negedge clk);
                look(TBL[i].set, TBL[i].tag);
                chk("R1 R2 R3 table hit", 64'(hit), 64'(TBL[i].eh));
                chk("R1 R2 table ppn", 64'(ppn), 64'(TBL[i].ep));
                chk("R4 R5 R7 table free", 64'({fvld, fway}), 64'({TBL[i].efv, TBL[i].efw}));
            end
        end

        // R8: a same-cycle lookup sees the old contents, and the new entry appears after the edge
        @(negedge clk);
        rf_req = 1'b1; rf_va = mkva(4'd1, 8'h44); rf_ppn = 40'h444; hv = 1'b1; hw = 3'd7;
        look(4'd1, 8'h44);
        chk("R8 same-cycle miss", 64'(hit), 64'd0);
        @(negedge clk);
        rf_req = 1'b0; hv = 1'b0;
        look(4'd1, 8'h44);
        chk("R8 next-cycle hit", 64'({hit, ppn}), 64'({1'b1, 40'h444}));

        // R4: fill set 6 completely, then check that no way is reported free
        for (int w = 7; w >= 0; w--) refill(4'd6, 8'h60 + 8'(w), 40'h600 + 40'(w), 1'b1, 3'(w));
        look(4'd6, 8'h99);
        chk("R4 full set free flag", 64'(fvld), 64'd0);
        look(4'd6, 8'h63);
        chk("R4 R5 full set entry", 64'({hit, ppn}), 64'({1'b1, 40'h603}));

        // R6: random replacement displaces exactly one old entry
        refill(4'd6, 8'h70, 40'h700, 1'b0, 3'd0);
        look(4'd6, 8'h70);
        chk("R6 victim entry hit", 64'({hit, ppn}), 64'({1'b1, 40'h700}));
        olds = 0;
        for (int w = 0; w < 8; w++) begin
            look(4'd6, 8'h60 + 8'(w));
            if (hit) olds++;
        end
        chk("R6 survivors", 64'(olds), 64'd7);

        // R9: a flush beats a same-cycle refill and empties every set
        @(negedge clk);
        flush = 1'b1; rf_req = 1'b1; rf_va = mkva(4'd2, 8'h55); rf_ppn = 40'h555;
        @(negedge clk);
        flush = 1'b0; rf_req = 1'b0;
        look(4'd2, 8'h55);
        chk("R9 flush beats refill", 64'({hit, fvld, fway}), 64'({1'b0, 1'b1, 3'd7}));
        look(4'd6, 8'h70);
        chk("R9 flush clears set 6", 64'({hit, fvld, fway}), 64'({1'b0, 1'b1, 3'd7}));
        look(4'd3, 8'h11);
        chk("R9 flush clears set 3", 64'(hit), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule